// File: doc/BRIEF.md
# Dual-Rail Weak-Conditioned Half Buffer Stage

This block is one stage of a self-timed pipeline, modelled as clocked, synthesizable logic. A word of `NBITS` bits enters on a left channel and leaves on a right channel. Each bit is carried on a false rail and a true rail. Raising exactly one rail of a bit both carries its value and marks it as valid. A spacer is the state in which every rail is low.

Both channels follow a four-phase, return-to-zero handshake, and both acknowledges are active low. Each output rail is a C-element state register with two conditions: the matching input rail and the right acknowledge. It sets when both are high, clears when both are low, and holds otherwise. The left acknowledge comes from an `NBITS`-input C-element over the per-bit output completion signals. As a result it changes only when the whole output word is valid or the whole word is neutral.

The stage holds at most one token across its two channels. A bit that arrives with both rails high is illegal. It is flagged on a protocol-error output and is kept out of the output rails.

Top module: `wchb_stage`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, every output rail is low, `left_ack_n` is high and `proto_err` is low.
- R2: When a bit arrives legally valid (value v: `left_t`=v, `left_f`=!v) and `right_ack_n` is high, the matching output rail (`right_t` for 1, `right_f` for 0) is high one clock later and the other rail of that bit stays low.
- R3: `left_ack_n` falls one clock after every output bit is valid, which is two clocks after a full valid word is presented. It stays high while any output bit is still neutral.
- R4: A valid input presented while `right_ack_n` is low leaves the output rails neutral. The token is passed one clock after `right_ack_n` goes high.
- R5: Once a token is on the output, its rails hold while the input is neutral but `right_ack_n` is still high. They also hold while `right_ack_n` is low but the input is still valid.
- R6: An output bit clears one clock after its input rails are both low and `right_ack_n` is low. `left_ack_n` rises one clock after every output bit is neutral.
- R7: If output bits clear at different times, `left_ack_n` stays low until the last bit is neutral.
- R8: An input bit with both rails high raises `proto_err` one clock later. Neither output rail of that bit rises. The other legal bits still pass, and `left_ack_n` does not fall, because the word never completes. `proto_err` is low one clock after no bit is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst | input | 1 | Synchronous active-high reset |
| left_f | input | NBITS | Left channel false rails |
| left_t | input | NBITS | Left channel true rails |
| left_ack_n | output | 1 | Active-low acknowledge to the left environment |
| right_f | output | NBITS | Right channel false rails |
| right_t | output | NBITS | Right channel true rails |
| right_ack_n | input | 1 | Active-low acknowledge from the right environment |
| proto_err | output | 1 | High the cycle after any input bit has both rails high |

## Verification
Two functions can land in the same cycle: detecting an illegal code and passing a token. The bench provokes this by presenting a word in which one bit has both rails high and the other bits carry legal values. The result is judged at the ports. `proto_err` must rise while the legal bits appear on their correct rails, the illegal bit's output rails must stay low, and `left_ack_n` must stay high because completion is never reached. A second overlap is a partial clear, where some output bits return to neutral while others are still valid. `left_ack_n` is checked to stay low until the last bit clears.

// File: rtl/wchb_pkg.sv
package wchb_pkg;

    // One dual-rail bit: exactly one rail high means valid, both low means spacer.
    typedef struct packed {
        logic t;
        logic f;
    } drail_t;

    function automatic logic dr_valid(drail_t b);
        return b.t ^ b.f;
    endfunction

    function automatic logic dr_illegal(drail_t b);
        return b.t & b.f;
    endfunction

endpackage

// File: rtl/wchb_celem.sv
module wchb_celem #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] req,
    output logic             state_q
);
    // Set when all conditions are high, clear when all are low, hold otherwise.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= 1'b0;
        else if (&req)
            state_q <= 1'b1;
        else if (~|req)
            state_q <= 1'b0;
    end
endmodule

// File: rtl/wchb_rail_cell.sv
module wchb_rail_cell
    import wchb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  drail_t in_bit,
    input  logic   rdy,
    output drail_t out_bit,
    output logic   bit_done,
    output logic   bit_bad
);
    logic t_q, f_q;
    logic bad;

    assign bad = dr_illegal(in_bit);

    // An illegal code never counts as a set condition for either rail.
    wchb_celem #(.WIDTH(2)) t_cel (
        .clk     (clk),
        .rst     (rst),
        .req     ({in_bit.t & ~bad, rdy}),
        .state_q (t_q)
    );

    wchb_celem #(.WIDTH(2)) f_cel (
        .clk     (clk),
        .rst     (rst),
        .req     ({in_bit.f & ~bad, rdy}),
        .state_q (f_q)
    );

    assign out_bit  = '{t: t_q, f: f_q};
    assign bit_done = dr_valid(out_bit);
    assign bit_bad  = bad;
endmodule

// File: rtl/wchb_stage.sv
module wchb_stage
    import wchb_pkg::*;
#(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] left_f,
    input  logic [NBITS-1:0] left_t,
    output logic             left_ack_n,
    output logic [NBITS-1:0] right_f,
    output logic [NBITS-1:0] right_t,
    input  logic             right_ack_n,
    output logic             proto_err
);
    logic [NBITS-1:0] done_vec;
    logic [NBITS-1:0] bad_vec;
    logic             word_done;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        drail_t ob;
        wchb_rail_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .in_bit   ('{t: left_t[i], f: left_f[i]}),
            .rdy      (right_ack_n),
            .out_bit  (ob),
            .bit_done (done_vec[i]),
            .bit_bad  (bad_vec[i])
        );
        assign right_t[i] = ob.t;
        assign right_f[i] = ob.f;
    end

    // Word completion: changes only on all-valid or all-neutral output.
    wchb_celem #(.WIDTH(NBITS)) done_cel (
        .clk     (clk),
        .rst     (rst),
        .req     (done_vec),
        .state_q (word_done)
    );

    assign left_ack_n = ~word_done;

    always_ff @(posedge clk) begin
        if (rst)
            proto_err <= 1'b0;
        else
            proto_err <= |bad_vec;
    end
endmodule

// File: rtl/wchb_stage_chk.sv
module wchb_stage_chk #(
    parameter int NBITS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NBITS-1:0] left_f,
    input logic [NBITS-1:0] left_t,
    input logic             left_ack_n,
    input logic [NBITS-1:0] right_f,
    input logic [NBITS-1:0] right_t,
    input logic             right_ack_n,
    input logic             proto_err
);
    // R3
    ack_fall_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(left_ack_n) |-> &(right_t ^ right_f));

    // R6
    ack_rise_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(left_ack_n) |-> ((right_t | right_f) == '0));

    // R2
    true_set_cond_chk: assert property (@(posedge clk) disable iff (rst)
        ((right_t & ~$past(right_t)) & ~($past(left_t) & {NBITS{$past(right_ack_n)}})) == '0);

    // R4
    false_set_cond_chk: assert property (@(posedge clk) disable iff (rst)
        ((right_f & ~$past(right_f)) & ~($past(left_f) & {NBITS{$past(right_ack_n)}})) == '0);

    // R6
    rail_clear_cond_chk: assert property (@(posedge clk) disable iff (rst)
        ((~right_t & $past(right_t)) & ($past(left_t) | {NBITS{$past(right_ack_n)}})) == '0);

    // R8
    no_double_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (right_t & right_f) == '0);

    // R8
    err_needs_bad_chk: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> ($past(left_t & left_f) != '0));
endmodule

bind wchb_stage wchb_stage_chk #(.NBITS(NBITS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .left_f      (left_f),
    .left_t      (left_t),
    .left_ack_n  (left_ack_n),
    .right_f     (right_f),
    .right_t     (right_t),
    .right_ack_n (right_ack_n),
    .proto_err   (proto_err)
);

// File: tb/wchb_stage_tb.sv
module wchb_stage_tb_top;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] left_f = '0;
    logic [N-1:0] left_t = '0;
    logic         left_ack_n;
    logic [N-1:0] right_f;
    logic [N-1:0] right_t;
    logic         right_ack_n = 1'b1;
    logic         proto_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    wchb_stage #(.NBITS(N)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .left_f      (left_f),
        .left_t      (left_t),
        .left_ack_n  (left_ack_n),
        .right_f     (right_f),
        .right_t     (right_t),
        .right_ack_n (right_ack_n),
        .proto_err   (proto_err)
    );

    // Each entry: {value, expected true rails, expected false rails}
    localparam logic [11:0] VEC [8] = '{
        {4'h0, 4'h0, 4'hF}, {4'hF, 4'hF, 4'h0},
        {4'h5, 4'h5, 4'hA}, {4'hA, 4'hA, 4'h5},
        {4'h3, 4'h3, 4'hC}, {4'hC, 4'hC, 4'h3},
        {4'h9, 4'h9, 4'h6}, {4'h6, 4'h6, 4'h9}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step();
        step();
        // R1: during reset
        check(right_t == 0 && right_f == 0 && left_ack_n && !proto_err, "R1",
              {right_t, right_f, 3'b0, left_ack_n, 3'b0, proto_err}, 32'h0010);
        rst = 1'b0;
        step();
        // R1: first cycle after reset
        check(right_t == 0 && right_f == 0 && left_ack_n && !proto_err, "R1",
              {right_t, right_f, 3'b0, left_ack_n, 3'b0, proto_err}, 32'h0010);

        // Table walk: full four-phase handshake per entry.
        for (int k = 0; k < 8; k++) begin
            logic [3:0] v, et, ef;
            {v, et, ef} = VEC[k];
            left_t = v;
            left_f = ~v;
            step();
            check(right_t == et && right_f == ef, "R2", {right_t, right_f}, {et, ef});
            check(left_ack_n == 1'b1, "R3", left_ack_n, 1);
            step();
            check(left_ack_n == 1'b0, "R3", left_ack_n, 0);
            left_t = '0;
            left_f = '0;
            step();
            check(right_t == et && right_f == ef, "R5", {right_t, right_f}, {et, ef});
            right_ack_n = 1'b0;
            step();
            check(right_t == 0 && right_f == 0, "R6", {right_t, right_f}, 0);
            check(left_ack_n == 1'b0, "R6", left_ack_n, 0);
            step();
            check(left_ack_n == 1'b1, "R6", left_ack_n, 1);
            right_ack_n = 1'b1;
            step();
        end

        // R4: right not ready
        right_ack_n = 1'b0;
        left_t = 4'h6;
        left_f = 4'h9;
        step();
        step();
        check(right_t == 0 && right_f == 0, "R4", {right_t, right_f}, 0);
        check(left_ack_n == 1'b1, "R4", left_ack_n, 1);
        right_ack_n = 1'b1;
        step();
        check(right_t == 4'h6 && right_f == 4'h9, "R4", {right_t, right_f}, 8'h69);
        // R5: right acks while input still valid -> hold
        step();
        right_ack_n = 1'b0;
        step();
        check(right_t == 4'h6 && right_f == 4'h9, "R5", {right_t, right_f}, 8'h69);
        // R7: clear bit 0 only
        left_f[0] = 1'b0;
        step();
        check(right_t == 4'h6 && right_f == 4'h8, "R7", {right_t, right_f}, 8'h68);
        step();
        check(left_ack_n == 1'b0, "R7", left_ack_n, 0);
        left_t = '0;
        left_f = '0;
        step();
        check(right_t == 0 && right_f == 0, "R6", {right_t, right_f}, 0);
        step();
        check(left_ack_n == 1'b1, "R7", left_ack_n, 1);
        right_ack_n = 1'b1;
        step();

        // R3: partial word does not complete
        left_t = 4'h1;
        step();
        step();
        check(right_t == 4'h1 && right_f == 0, "R2", {right_t, right_f}, 8'h10);
        check(left_ack_n == 1'b1, "R3", left_ack_n, 1);
        left_f = 4'hE;
        step();
        step();
        check(left_ack_n == 1'b0, "R3", left_ack_n, 0);
        left_t = '0;
        left_f = '0;
        right_ack_n = 1'b0;
        step();
        step();
        check(left_ack_n == 1'b1, "R6", left_ack_n, 1);
        right_ack_n = 1'b1;
        step();

        // R8: bit 2 illegal, others carry value 1 on bit0, 0 on bits 1 and 3
        left_t = 4'h5;
        left_f = 4'hE;
        step();
        check(proto_err == 1'b1, "R8", proto_err, 1);
        check(right_t == 4'h1 && right_f == 4'hA, "R8", {right_t, right_f}, 8'h1A);
        step();
        check(left_ack_n == 1'b1, "R8", left_ack_n, 1);
        left_t = '0;
        left_f = '0;
        step();
        check(proto_err == 1'b0, "R8", proto_err, 0);
        right_ack_n = 1'b0;
        step();
        check(right_t == 0 && right_f == 0, "R8", {right_t, right_f}, 0);
        check(left_ack_n == 1'b1, "R8", left_ack_n, 1);
        right_ack_n = 1'b1;
        step();

        finish_run();
    end
endmodule